// File: doc/BRIEF.md
# Four-Level PWM Grayscale Segment Driver

This block drives the segment and common lines of a 16-common multiplexed display that shows four gray levels. The pixels sit in a display RAM as 2-bit codes, two pixels to a 4-bit word. For each common, the block reads that common's row from the RAM through a simple read port with one cycle of latency, holds it in a row buffer, and then steps through a run of equal time sections. During the sections each segment is driven active for a number of sections set by the gray level of its pixel.

Four 5-bit width registers, one per gray level, are written through a small command port that carries a level number and a width. A frame mode input selects a slow mode with 24 sections per common or a fast mode with 13. Widths too large for the current mode saturate at the last usable section count and do not wrap. The next row is fetched while the current common is shown, so the commons follow each other without gaps. When the display enable is low, every segment and common line is held inactive.

Top module: `grayseg_drv`

## Requirements
- R1: Pixel code 2'b11 selects gray level 1, 2'b10 level 2, 2'b01 level 3 and 2'b00 level 4.
- R2: A level write with `lvl_num` of 1, 2, 3 or 4 loads `lvl_pwm` into the width register of that level. A write with `lvl_num` of 0, 5, 6 or 7 changes no width register.
- R3: In slow mode each common lasts 24 sections, and a width above 23 acts as 23.
- R4: In fast mode each common lasts 13 sections, and a width above 12 acts as 12.
- R5: In section s (counted from 0) of a common, a segment is active exactly when s is below the clamped width of its pixel's level. A segment therefore only turns on at the start of a common.
- R6: `com_out` is one-hot with bit c high for common c. The commons run in order 0 to 15, each for one full run of sections, and common 0 follows common 15.
- R7: Slow mode is selected after reset. A mode write during a common takes effect from the next common on, for both the section count and the clamp.
- R8: Segments are mapped to the RAM as follows. Word w of common c is at address c*(NSEG/2)+w. Bits 3:2 of that word hold segment 2w and bits 1:0 hold segment 2w+1.
- R9: While `disp_on` is low, `com_out` and `seg_out` are all zero from the next cycle on. When `disp_on` is raised, the display starts at common 0, section 0, once that common's row has been fetched.
- R10: After reset `com_out`, `seg_out` and `ram_re` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_on | input | 1 | Display enable |
| mode_we | input | 1 | Frame mode write strobe |
| mode_fast | input | 1 | Mode written by `mode_we`: 1 fast (13 sections), 0 slow (24 sections) |
| lvl_we | input | 1 | Level width write strobe |
| lvl_num | input | 3 | Level number 1..4; other values are ignored |
| lvl_pwm | input | PWM_W | Width in sections for the addressed level |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | $clog2(NCOM*NSEG/2) | RAM word address |
| ram_rdata | input | 4 | RAM word, valid the cycle after the address |
| com_out | output | NCOM | One-hot selected common, active high |
| seg_out | output | NSEG | Segment active flags, active high |

## Verification
The assertions rely on three conditions. The level widths and the RAM contents only change while `disp_on` is low, so a segment can never rise in the middle of a common. The RAM returns data exactly one cycle after the address. A row fetch of NSEG/2+2 cycles fits inside the shortest common. The bench keeps to all three: it loads widths, RAM patterns and mode changes only with the display off, except for the single mode write that tests when a mode change takes effect. It models the RAM with a one-cycle registered read, and it uses 8 segments with one clock per section.

// File: rtl/grayseg_drv.sv
module grayseg_drv #(
  parameter int NSEG      = 8,
  parameter int NCOM      = 16,
  parameter int SEC_DIV   = 1,
  parameter int PWM_W     = 5,
  parameter int SLOW_SECS = 24,
  parameter int FAST_SECS = 13,
  localparam int NWORD = NSEG / 2,
  localparam int CW    = $clog2(NCOM),
  localparam int WW    = (NWORD > 1) ? $clog2(NWORD) : 1,
  localparam int AW    = $clog2(NCOM * NWORD),
  localparam int DW    = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_on,
  input  logic             mode_we,
  input  logic             mode_fast,
  input  logic             lvl_we,
  input  logic [2:0]       lvl_num,
  input  logic [PWM_W-1:0] lvl_pwm,
  output logic             ram_re,
  output logic [AW-1:0]    ram_addr,
  input  logic [3:0]       ram_rdata,
  output logic [NCOM-1:0]  com_out,
  output logic [NSEG-1:0]  seg_out
);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_RUN} st_t;

  st_t              st;
  logic [PWM_W-1:0] pwm_q [4];
  logic             fast_cfg, fast_act;
  logic [CW-1:0]    com_q;
  logic [PWM_W-1:0] sec_q;
  logic [DW-1:0]    div_q;
  logic             f_busy;
  logic [WW-1:0]    f_idx;
  logic [CW-1:0]    f_line;
  logic             rd_vld;
  logic [WW-1:0]    rd_idx;
  logic [3:0]       nxt_buf [NWORD];
  logic [3:0]       act_buf [NWORD];

  function automatic logic [CW-1:0] line_after(input logic [CW-1:0] x);
    return (x == CW'(NCOM - 1)) ? '0 : x + 1'b1;
  endfunction

  logic             running, tick, lw_ok;
  logic [1:0]       lw_idx;
  logic [PWM_W-1:0] last_sec;
  logic [PWM_W-1:0] lim [4];

  assign running  = (st == S_RUN);
  assign tick     = (div_q == DW'(SEC_DIV - 1));
  assign last_sec = fast_act ? PWM_W'(FAST_SECS - 1) : PWM_W'(SLOW_SECS - 1);
  assign lw_ok    = lvl_we && (lvl_num != 3'd0) && (lvl_num <= 3'd4);
  assign lw_idx   = 2'(lvl_num - 3'd1);
  assign ram_re   = f_busy;
  assign ram_addr = AW'(int'(f_line) * NWORD + int'(f_idx));
  assign com_out  = running ? (NCOM'(1) << com_q) : '0;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim[g] = (pwm_q[g] > last_sec) ? last_sec : pwm_q[g];
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [1:0] code;
    logic [1:0] lv;
    assign code       = (s % 2 == 0) ? act_buf[s/2][3:2] : act_buf[s/2][1:0];
    assign lv         = ~code;
    assign seg_out[s] = running && (sec_q < lim[lv]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      fast_cfg <= 1'b0;
      fast_act <= 1'b0;
      com_q    <= '0;
      sec_q    <= '0;
      div_q    <= '0;
      f_busy   <= 1'b0;
      f_idx    <= '0;
      f_line   <= '0;
      rd_vld   <= 1'b0;
      rd_idx   <= '0;
      for (int i = 0; i < 4; i++) pwm_q[i] <= '0;
      for (int i = 0; i < NWORD; i++) begin
        nxt_buf[i] <= '0;
        act_buf[i] <= '0;
      end
    end else begin
      if (lw_ok) pwm_q[lw_idx] <= lvl_pwm;
      if (mode_we) fast_cfg <= mode_fast;

      rd_vld <= f_busy;
      rd_idx <= f_idx;
      if (rd_vld) nxt_buf[rd_idx] <= ram_rdata;
      if (f_busy) begin
        f_idx <= f_idx + 1'b1;
        if (f_idx == WW'(NWORD - 1)) f_busy <= 1'b0;
      end

      if (!disp_on) begin
        st     <= S_IDLE;
        f_busy <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            st     <= S_PRE;
            f_busy <= 1'b1;
            f_idx  <= '0;
            f_line <= '0;
          end
          S_PRE: begin
            if (!f_busy && !rd_vld) begin
              st       <= S_RUN;
              act_buf  <= nxt_buf;
              com_q    <= '0;
              sec_q    <= '0;
              div_q    <= '0;
              fast_act <= fast_cfg;
              f_busy   <= 1'b1;
              f_idx    <= '0;
              f_line   <= line_after('0);
            end
          end
          default: begin
            if (tick) begin
              div_q <= '0;
              if (sec_q == last_sec) begin
                sec_q    <= '0;
                com_q    <= line_after(com_q);
                act_buf  <= nxt_buf;
                fast_act <= fast_cfg;
                f_busy   <= 1'b1;
                f_idx    <= '0;
                f_line   <= line_after(line_after(com_q));
              end else begin
                sec_q <= sec_q + 1'b1;
              end
            end else begin
              div_q <= div_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/grayseg_drv_chk.sv
module grayseg_drv_chk #(
  parameter int NSEG      = 8,
  parameter int NCOM      = 16,
  parameter int SEC_DIV   = 1,
  parameter int SLOW_SECS = 24,
  parameter int FAST_SECS = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_on,
  input logic [NCOM-1:0] com_out,
  input logic [NSEG-1:0] seg_out
);

  logic [NCOM-1:0] prev_com;
  int              len;
  int              on0;
  logic            com_step;

  assign com_step = (com_out != prev_com) && (prev_com != '0) && (com_out != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_com <= '0;
      len      <= 0;
      on0      <= 0;
    end else begin
      prev_com <= com_out;
      if (com_out != prev_com) begin
        len <= 1;
        on0 <= seg_out[0] ? 1 : 0;
      end else begin
        len <= len + 1;
        on0 <= on0 + (seg_out[0] ? 1 : 0);
      end
    end
  end

  p_com_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_out));

  p_com_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    com_step |-> (com_out == {prev_com[NCOM-2:0], prev_com[NCOM-1]}));

  p_com_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    com_step |-> (len == SLOW_SECS * SEC_DIV || len == FAST_SECS * SEC_DIV));

  p_seg_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    on0 <= (SLOW_SECS - 1) * SEC_DIV);

  p_seg_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((seg_out & ~$past(seg_out)) != '0) |-> (com_out != prev_com));

  p_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |=> (com_out == '0 && seg_out == '0));

  p_seg_com_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_out != '0) |-> (com_out != '0));

endmodule

bind grayseg_drv grayseg_drv_chk #(
  .NSEG(NSEG), .NCOM(NCOM), .SEC_DIV(SEC_DIV),
  .SLOW_SECS(SLOW_SECS), .FAST_SECS(FAST_SECS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_on(disp_on),
  .com_out(com_out), .seg_out(seg_out)
);

// File: tb/grayseg_drv_tb.sv
`timescale 1ns/1ps
module grayseg_drv_tb;
  localparam int NSEG  = 8;
  localparam int NCOM  = 16;
  localparam int NWORD = NSEG / 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n, disp_on, mode_we, mode_fast, lvl_we;
  logic [2:0]      lvl_num;
  logic [4:0]      lvl_pwm;
  logic            ram_re;
  logic [5:0]      ram_addr;
  logic [3:0]      ram_rdata;
  logic [NCOM-1:0] com_out;
  logic [NSEG-1:0] seg_out;

  grayseg_drv #(.NSEG(NSEG), .NCOM(NCOM)) u_dut (
    .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .mode_we(mode_we),
    .mode_fast(mode_fast), .lvl_we(lvl_we), .lvl_num(lvl_num), .lvl_pwm(lvl_pwm),
    .ram_re(ram_re), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .com_out(com_out), .seg_out(seg_out)
  );

  logic [3:0] mem [NCOM*NWORD];
  always @(posedge clk) ram_rdata <= mem[ram_addr];

  int pw [4];
  bit fast_m;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_lvl(input int n, input int v);
    @(negedge clk);
    lvl_we = 1'b1; lvl_num = n[2:0]; lvl_pwm = v[4:0];
    @(negedge clk);
    lvl_we = 1'b0;
    if (n >= 1 && n <= 4) pw[n-1] = v;
  endtask

  task automatic set_mode(input bit f);
    @(negedge clk);
    mode_we = 1'b1; mode_fast = f;
    @(negedge clk);
    mode_we = 1'b0;
    fast_m = f;
  endtask

  task automatic fill(input int kind);
    for (int a = 0; a < NCOM*NWORD; a++) begin
      case (kind)
        0: mem[a] = 4'((a * 7 + 3) % 16);
        1: mem[a] = 4'(a ^ 10);
        default: mem[a] = 4'((a * 5 + a / 4) % 16);
      endcase
    end
  endtask

  function automatic bit exp_seg(input int c, input int s, input int k, input bit f);
    logic [3:0] w;
    int code, v, cap;
    w = mem[c*NWORD + k/2];
    code = (k % 2 == 0) ? int'(w[3:2]) : int'(w[1:0]);
    v = pw[3 - code];
    cap = f ? 12 : 23;
    if (v > cap) v = cap;
    return s < v;
  endfunction

  task automatic run_coms(input int n, input int sw_at, input string req);
    int w;
    bit f;
    logic [NSEG-1:0] e;
    @(negedge clk);
    disp_on = 1'b1;
    w = 0;
    do begin
      @(negedge clk);
      w++;
    end while (com_out == '0 && w < 100);
    chk(com_out == 16'd1, "R9 start at common 0", com_out, 1);
    f = fast_m;
    for (int o = 0; o < n; o++) begin
      int c, ns;
      c = o % NCOM;
      if (o == sw_at) f = 1'b1;
      ns = f ? 13 : 24;
      for (int s = 0; s < ns; s++) begin
        for (int k = 0; k < NSEG; k++) e[k] = exp_seg(c, s, k, f);
        chk(com_out == (16'd1 << c), "R6 common order", com_out, 16'd1 << c);
        chk(seg_out == e, req, seg_out, e);
        if (o == sw_at - 1 && s == 5) begin
          mode_we = 1'b1; mode_fast = 1'b1;
        end else begin
          mode_we = 1'b0;
        end
        @(negedge clk);
      end
    end
    mode_we = 1'b0;
    if (sw_at >= 0) fast_m = 1'b1;
  endtask

  task automatic go_dark();
    disp_on = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(com_out == '0 && seg_out == '0, "R9 display off", {com_out, seg_out}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; disp_on = 1'b0; mode_we = 1'b0; mode_fast = 1'b0;
    lvl_we = 1'b0; lvl_num = '0; lvl_pwm = '0;
    for (int i = 0; i < 4; i++) pw[i] = 0;
    fast_m = 1'b0;
    fill(0);
    repeat (3) @(negedge clk);
    chk(com_out == '0 && seg_out == '0 && ram_re == 1'b0, "R10 reset state",
        {ram_re, com_out, seg_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(com_out == '0 && seg_out == '0 && ram_re == 1'b0, "R10 after reset",
        {ram_re, com_out, seg_out}, 0);

    // R7 default slow, R1 R5 R8 mapping, R6 wrap over 17 commons
    set_lvl(1, 31); set_lvl(2, 17); set_lvl(3, 5); set_lvl(4, 0);
    run_coms(17, -1, "R1 R5 R7 R8 slow default");
    go_dark();

    // R2 writes to level numbers outside 1..4 are dropped
    set_lvl(0, 3); set_lvl(5, 3); set_lvl(6, 9); set_lvl(7, 3);
    fill(1);
    run_coms(16, -1, "R2 ignored level numbers");
    go_dark();

    // R3 slow clamp at 23
    set_lvl(1, 24); set_lvl(2, 23); set_lvl(3, 0); set_lvl(4, 12);
    run_coms(16, -1, "R3 slow clamp");
    go_dark();

    // R4 fast mode and clamp at 12
    set_mode(1'b1);
    set_lvl(1, 13); set_lvl(2, 12); set_lvl(3, 1); set_lvl(4, 31);
    fill(2);
    run_coms(16, -1, "R4 fast clamp");
    go_dark();

    set_lvl(1, 0); set_lvl(2, 6); set_lvl(3, 11); set_lvl(4, 2);
    fill(0);
    run_coms(16, -1, "R4 R5 fast widths");
    go_dark();

    // R7 mode change applies from the next common on
    set_mode(1'b0);
    set_lvl(1, 20); set_lvl(2, 15); set_lvl(3, 8); set_lvl(4, 3);
    run_coms(8, 4, "R7 mode switch at boundary");
    go_dark();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule